// File: doc/BRIEF.md
# BCD Calendar Clock with Indexed Register Port

This block is a real-time clock. It counts seconds, minutes, hours, weekday, day, month and a two-digit year, and it holds every field as packed BCD. A one-second enable input (`tick_1hz`) starts each update. A faster base enable (`base_en`) does two jobs: it times the update-in-progress window, and it drives the periodic interrupt divider.

The host has two ports. A write to the index port selects one byte of a 128-byte space. A read or write on the data port then reaches that byte. The space holds:
- the time fields;
- three alarm bytes;
- four control and status bytes;
- general-purpose RAM.

The host sets the time in three steps. It raises the freeze bit, writes the BCD fields, and then clears the freeze bit. Before it reads the time, it polls the busy flag and waits for it to clear. Pending events show in a flags byte, and reading that byte clears them. The `irq` output stays high while any flag whose enable bit is set is pending.

Top module: `calclock_top`

## Requirements
- R1: A write with `host_port_sel`=0 stores `host_wdata[6:0]` as the index; bit 7 is ignored. A read or write with `host_port_sel`=1 reaches the byte at that index. `host_rdata` shows that byte in the same cycle. Reading with `host_port_sel`=0 returns the index.
- R2: Bytes 0x0E to 0x7F are plain storage and read back what was last written. Byte 0x09 holds the year and is also read/write.
- R3: Time fields sit at these indexes: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06, day 0x07, month 0x08, year 0x09. On each update the seconds field advances in BCD. The carries run as follows:
  - seconds 59 to 00 carries into minutes;
  - minutes 59 to 00 carries into hours;
  - hours 23 to 00 advances the weekday (7 to 1) and the day;
  - the last day of the month goes to 01 and advances the month;
  - month 12 goes to 01 and advances the year;
  - year 99 goes to 00.
- R4: April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R5: A tick while counting is enabled sets bit 7 of byte 0x0A (busy). The time fields advance on the edge that takes the UIP_CYCLES-th `base_en` pulse after the tick, and busy clears on that same edge. Bit 7 of byte 0x0A cannot be written; bits 6:0 are read/write.
- R6: Bit 7 of byte 0x0B is the freeze bit. While it is 1, ticks are ignored, the busy flag is held at 0 and the time fields change only through host writes. Clearing it lets ticks take effect again. Bit 1 of byte 0x0B is the 24-hour select and is read/write; hours always count 00 to 23.
- R7: Alarm bytes sit at 0x01 (seconds), 0x03 (minutes) and 0x05 (hours). When an update produces a time that matches all three, the alarm flag (bit 5 of byte 0x0C) is set. An alarm byte whose top two bits are 11 matches any value.
- R8: When bit 5 of byte 0x0A is 1 and the rate code r in bits 3:0 of byte 0x0A is not 0, the periodic flag (bit 6 of byte 0x0C) is set once every 2^(r-1) `base_en` pulses. A write to byte 0x0A restarts this count. A rate code of 0 never sets the flag.
- R9: Byte 0x0C reads as follows:
  - bit 6 is the periodic flag;
  - bit 5 is the alarm flag;
  - bit 4 is the update-done flag, which is set on every update;
  - bit 7 is 1 when any flag is set together with its enable bit;
  - bits 3:0 read 0.
  A data read of 0x0C clears the flags, except for any flag set in the same cycle. Writes to 0x0C are ignored.
- R10: `irq` is high exactly while a flag is set together with its enable bit in byte 0x0B. Bit 6 enables the periodic flag, bit 5 the alarm flag and bit 4 the update-done flag.
- R11: Byte 0x0D always reads 0x80, and writes to it are ignored.
- R12: After reset the registers hold these values:
  - time 00:00:00, weekday 01, day 01, month 01, year 00;
  - byte 0x0A = 0x00, byte 0x0B = 0x02;
  - byte 0x0C = 0x00, `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| base_en | input | 1 | Base rate enable for the busy window and the periodic divider |
| host_port_sel | input | 1 | 0 selects the index port, 1 the data port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the selected port |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench goes after the carry chain at its edges, one case for each edge:
- A year wrap on 31 December. A design that wraps the year at the wrong value shows up here.
- 30-day months. A design that lets April run to 31 is caught here.
- February in a leap year and in a common year. A design that gets the divisible-by-4 test wrong gives the wrong February length.
- The weekday wrap from 7 to 1.

It reads the seconds while the busy flag is up, so an update that lands early is seen as a changed field. It checks that a frozen clock ignores ticks.

For alarms it covers an exact match, a match through don't-care bytes and a near miss. A match test that ignores the don't-care code would miss the second case.

The periodic divider is stepped one `base_en` pulse at a time. An off-by-one period, or a count that does not restart when the rate is written, sets the flag one pulse early or late.

Flag reads are checked for the clear-on-read behaviour and for the summary bit following the enable bits.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    localparam int IDX_W = 7;

    localparam logic [IDX_W-1:0] IX_SEC    = 7'h00;
    localparam logic [IDX_W-1:0] IX_ASEC   = 7'h01;
    localparam logic [IDX_W-1:0] IX_MIN    = 7'h02;
    localparam logic [IDX_W-1:0] IX_AMIN   = 7'h03;
    localparam logic [IDX_W-1:0] IX_HOUR   = 7'h04;
    localparam logic [IDX_W-1:0] IX_AHOUR  = 7'h05;
    localparam logic [IDX_W-1:0] IX_WDAY   = 7'h06;
    localparam logic [IDX_W-1:0] IX_DAY    = 7'h07;
    localparam logic [IDX_W-1:0] IX_MONTH  = 7'h08;
    localparam logic [IDX_W-1:0] IX_YEAR   = 7'h09;
    localparam logic [IDX_W-1:0] IX_CTL    = 7'h0A;
    localparam logic [IDX_W-1:0] IX_MODE   = 7'h0B;
    localparam logic [IDX_W-1:0] IX_FLAGS  = 7'h0C;
    localparam logic [IDX_W-1:0] IX_STAT   = 7'h0D;
    localparam logic [IDX_W-1:0] IX_RAM_LO = 7'h0E;

    localparam int RAM_LO = 14;
    localparam int RAM_HI = (1 << IDX_W) - 1;

    // Calendar state, every field packed BCD
    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] day;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by four
    function automatic logic bcd_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] bcd_month_len(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar_step.sv
`timescale 1ns/1ps
module rtc_calendar_step
    import rtc_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic sec_wrap, min_wrap, hour_wrap, day_wrap, month_wrap;
    logic [7:0] mlen;

    always_comb begin
        nxt        = cur;
        mlen       = bcd_month_len(cur.month, cur.year);
        sec_wrap   = (cur.sec >= 8'h59);
        min_wrap   = sec_wrap && (cur.min >= 8'h59);
        hour_wrap  = min_wrap && (cur.hour >= 8'h23);
        day_wrap   = hour_wrap && (cur.day >= mlen);
        month_wrap = day_wrap && (cur.month >= 8'h12);

        nxt.sec = sec_wrap ? 8'h00 : bcd_inc(cur.sec);
        if (sec_wrap)   nxt.min   = min_wrap  ? 8'h00 : bcd_inc(cur.min);
        if (min_wrap)   nxt.hour  = hour_wrap ? 8'h00 : bcd_inc(cur.hour);
        if (hour_wrap) begin
            nxt.wday = (cur.wday >= 8'h07) ? 8'h01 : bcd_inc(cur.wday);
            nxt.day  = day_wrap ? 8'h01 : bcd_inc(cur.day);
        end
        if (day_wrap)   nxt.month = month_wrap ? 8'h01 : bcd_inc(cur.month);
        if (month_wrap) nxt.year  = (cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year);
    end
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match #(
    parameter int N_FIELDS = 3
) (
    input  logic [N_FIELDS-1:0][7:0] now,
    input  logic [N_FIELDS-1:0][7:0] target,
    output logic                     hit
);
    logic [N_FIELDS-1:0] field_ok;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        // top bits 11 make the byte a wildcard
        assign field_ok[i] = (target[i][7:6] == 2'b11) || (target[i] == now[i]);
    end

    assign hit = &field_ok;
endmodule

// File: rtl/rtc_periodic.sv
`timescale 1ns/1ps
module rtc_periodic #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_on,
    input  logic [RATE_W-1:0] rate,
    input  logic              restart,
    input  logic              base_en,
    output logic              pulse
);
    localparam int CNT_W = (1 << RATE_W) - 2;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] period_m1;
    logic             active;

    assign active    = chain_on && (rate != '0);
    assign period_m1 = (CNT_W'(1) << (rate - RATE_W'(1))) - CNT_W'(1);

    always_comb begin
        cnt_d = cnt_q;
        pulse = 1'b0;
        if (restart || !active) begin
            cnt_d = '0;
        end else if (base_en) begin
            if (cnt_q == period_m1) begin
                cnt_d = '0;
                pulse = 1'b1;
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/calclock_top.sv
`timescale 1ns/1ps
module calclock_top
    import rtc_pkg::*;
#(
    parameter int UIP_CYCLES = 8,
    parameter int RATE_W     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       base_en,
    input  logic       host_port_sel,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       irq
);
    localparam int UIP_W   = $clog2(UIP_CYCLES + 1);
    localparam int N_ALARM = 3;

    typedef struct packed {
        cal_t                   cal;
        logic [N_ALARM-1:0][7:0] alarm;   // [0] sec, [1] min, [2] hour
        logic [6:0]             ctl;      // byte 0x0A bits 6:0
        logic [7:0]             mode;     // byte 0x0B
        logic [2:0]             flags;    // periodic, alarm, update-done
        logic                   uip;
        logic [UIP_W-1:0]       uip_cnt;
        logic [IDX_W-1:0]       idx;
    } st_t;

    st_t  d, q;
    cal_t cal_next;
    logic alarm_hit, per_pulse, upd, freeze_next;
    logic idx_wr, data_wr, data_rd, flag_clr, ctl_write;
    logic [2:0] flag_set;
    logic irq_any;
    logic [7:0] ram [RAM_LO:RAM_HI];

    assign idx_wr    = host_wr && !host_port_sel;
    assign data_wr   = host_wr && host_port_sel;
    assign data_rd   = host_rd && host_port_sel;
    assign flag_clr  = data_rd && (q.idx == IX_FLAGS);
    assign ctl_write = data_wr && (q.idx == IX_CTL);

    rtc_calendar_step u_step (
        .cur (q.cal),
        .nxt (cal_next)
    );

    rtc_alarm_match #(.N_FIELDS(N_ALARM)) u_alarm (
        .now    ({cal_next.hour, cal_next.min, cal_next.sec}),
        .target (q.alarm),
        .hit    (alarm_hit)
    );

    rtc_periodic #(.RATE_W(RATE_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .chain_on (q.ctl[5]),
        .rate     (q.ctl[RATE_W-1:0]),
        .restart  (ctl_write),
        .base_en  (base_en),
        .pulse    (per_pulse)
    );

    assign irq_any = |(q.flags & q.mode[6:4]);
    assign irq     = irq_any;

    always_comb begin
        d   = q;
        upd = 1'b0;

        if (idx_wr) d.idx = host_wdata[IDX_W-1:0];

        freeze_next = (data_wr && q.idx == IX_MODE) ? host_wdata[7] : q.mode[7];

        // busy window then update
        if (freeze_next) begin
            d.uip     = 1'b0;
            d.uip_cnt = '0;
        end else if (q.uip) begin
            if (base_en) begin
                if (q.uip_cnt == UIP_W'(UIP_CYCLES - 1)) begin
                    upd       = 1'b1;
                    d.uip     = 1'b0;
                    d.uip_cnt = '0;
                end else begin
                    d.uip_cnt = q.uip_cnt + UIP_W'(1);
                end
            end
        end else if (tick_1hz) begin
            d.uip     = 1'b1;
            d.uip_cnt = '0;
        end

        if (upd) d.cal = cal_next;

        flag_set = {per_pulse, upd && alarm_hit, upd};
        d.flags  = (flag_clr ? 3'b000 : q.flags) | flag_set;

        // host write wins over the update for the same field
        if (data_wr) begin
            case (q.idx)
                IX_SEC:   d.cal.sec   = host_wdata;
                IX_ASEC:  d.alarm[0]  = host_wdata;
                IX_MIN:   d.cal.min   = host_wdata;
                IX_AMIN:  d.alarm[1]  = host_wdata;
                IX_HOUR:  d.cal.hour  = host_wdata;
                IX_AHOUR: d.alarm[2]  = host_wdata;
                IX_WDAY:  d.cal.wday  = host_wdata;
                IX_DAY:   d.cal.day   = host_wdata;
                IX_MONTH: d.cal.month = host_wdata;
                IX_YEAR:  d.cal.year  = host_wdata;
                IX_CTL:   d.ctl       = host_wdata[6:0];
                IX_MODE:  d.mode      = host_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cal.wday <= 8'h01;
            q.cal.day  <= 8'h01;
            q.cal.month<= 8'h01;
            q.mode     <= 8'h02;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (data_wr && q.idx >= IX_RAM_LO) ram[q.idx] <= host_wdata;
    end

    always_comb begin
        if (!host_port_sel) begin
            host_rdata = {1'b0, q.idx};
        end else begin
            case (q.idx)
                IX_SEC:   host_rdata = q.cal.sec;
                IX_ASEC:  host_rdata = q.alarm[0];
                IX_MIN:   host_rdata = q.cal.min;
                IX_AMIN:  host_rdata = q.alarm[1];
                IX_HOUR:  host_rdata = q.cal.hour;
                IX_AHOUR: host_rdata = q.alarm[2];
                IX_WDAY:  host_rdata = q.cal.wday;
                IX_DAY:   host_rdata = q.cal.day;
                IX_MONTH: host_rdata = q.cal.month;
                IX_YEAR:  host_rdata = q.cal.year;
                IX_CTL:   host_rdata = {q.uip, q.ctl};
                IX_MODE:  host_rdata = q.mode;
                IX_FLAGS: host_rdata = {irq_any, q.flags, 4'b0000};
                IX_STAT:  host_rdata = 8'h80;
                default:  host_rdata = ram[q.idx];
            endcase
        end
    end
endmodule

// File: rtl/rtc_checker.sv
`timescale 1ns/1ps
module rtc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_port_sel,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] host_rdata,
    input logic       irq,
    input logic [6:0] idx,
    input logic [7:0] mode,
    input logic       uip,
    input logic [7:0] sec,
    input logic [2:0] flags,
    input logic [2:0] flag_set
);
    // R6: frozen clock never shows busy
    a_r6_freeze_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mode[7] |-> !uip);

    // R6: frozen clock without host writes keeps seconds
    a_r6_freeze_holds_sec: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode[7]) && !$past(host_wr)) |-> $stable(sec));

    // R9: reading flags leaves only freshly set ones
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_port_sel && idx == 7'h0C) |=> (flags == $past(flag_set)));

    // R10: interrupt needs a pending flag
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != 3'b000));

    // R11: status byte constant
    a_r11_status_const: assert property (@(posedge clk) disable iff (!rst_n)
        (host_port_sel && idx == 7'h0D) |-> (host_rdata == 8'h80));
endmodule

bind calclock_top rtc_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_port_sel (host_port_sel),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_rdata    (host_rdata),
    .irq           (irq),
    .idx           (q.idx),
    .mode          (q.mode),
    .uip           (q.uip),
    .sec           (q.cal.sec),
    .flags         (q.flags),
    .flag_set      (flag_set)
);

// File: tb/tb_calclock_top.sv
`timescale 1ns/1ps
module tb_calclock_top;
    localparam int UIP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1hz = 1'b0;
    logic base_en = 1'b1;
    logic host_port_sel = 1'b0;
    logic host_wr = 1'b0;
    logic host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] v;
    logic [7:0] junk;

    always #2 clk = ~clk;

    calclock_top #(.UIP_CYCLES(UIP)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .base_en(base_en),
        .host_port_sel(host_port_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus(input logic sel, input logic wr, input logic rd,
                       input logic [7:0] wd, output logic [7:0] rv);
        @(negedge clk);
        host_port_sel = sel; host_wr = wr; host_rd = rd; host_wdata = wd;
        #1 rv = host_rdata;
        @(posedge clk);
        #1 host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] val);
        bus(1'b0, 1'b1, 1'b0, a, junk);
        bus(1'b1, 1'b1, 1'b0, val, junk);
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] val);
        bus(1'b0, 1'b1, 1'b0, a, junk);
        bus(1'b1, 1'b0, 1'b1, 8'h00, val);
    endtask

    task automatic do_tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(posedge clk); #1 tick_1hz = 1'b0;
    endtask

    task automatic tick_and_wait();
        do_tick();
        repeat (UIP + 6) @(posedge clk);
    endtask

    task automatic pulse_base(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); base_en = 1'b1;
            @(posedge clk); #1 base_en = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] yr, mo, dy, wd, hr, mi, se);
        wr_reg(8'h0B, 8'h82);
        wr_reg(8'h09, yr); wr_reg(8'h08, mo); wr_reg(8'h07, dy);
        wr_reg(8'h06, wd); wr_reg(8'h04, hr); wr_reg(8'h02, mi);
        wr_reg(8'h00, se);
        wr_reg(8'h0B, 8'h02);
    endtask

    task automatic t_reset();
        check("R12 irq", {7'd0, irq}, 8'h00);
        rd_reg(8'h00, v); check("R12 sec", v, 8'h00);
        rd_reg(8'h07, v); check("R12 day", v, 8'h01);
        rd_reg(8'h08, v); check("R12 month", v, 8'h01);
        rd_reg(8'h0A, v); check("R12 ctl", v, 8'h00);
        rd_reg(8'h0B, v); check("R12 mode", v, 8'h02);
        rd_reg(8'h0C, v); check("R12 flags", v, 8'h00);
    endtask

    task automatic t_access();
        bus(1'b0, 1'b1, 1'b0, 8'h8E, junk);          // bit 7 of index dropped
        bus(1'b1, 1'b1, 1'b0, 8'hA5, junk);
        bus(1'b0, 1'b0, 1'b1, 8'h00, v); check("R1 index readback", v, 8'h0E);
        rd_reg(8'h0E, v); check("R1 R2 ram 0x0E", v, 8'hA5);
        wr_reg(8'h7F, 8'h3C);
        rd_reg(8'h7F, v); check("R2 ram 0x7F", v, 8'h3C);
        rd_reg(8'h0E, v); check("R2 ram 0x0E kept", v, 8'hA5);
        wr_reg(8'h09, 8'h47);
        rd_reg(8'h09, v); check("R2 year rw", v, 8'h47);
        wr_reg(8'h0D, 8'h00);
        rd_reg(8'h0D, v); check("R11 status", v, 8'h80);
        wr_reg(8'h0A, 8'hFF);
        rd_reg(8'h0A, v); check("R5 busy not writable", v, 8'h7F);
        wr_reg(8'h0A, 8'h00);
        wr_reg(8'h0B, 8'h00);
        rd_reg(8'h0B, v); check("R6 24h bit rw", v, 8'h00);
        wr_reg(8'h0B, 8'h02);
    endtask

    task automatic t_busy();
        set_time(8'h23, 8'h05, 8'h10, 8'h03, 8'h08, 8'h15, 8'h30);
        bus(1'b0, 1'b1, 1'b0, 8'h0A, junk);
        do_tick();
        bus(1'b1, 1'b0, 1'b1, 8'h00, v); check("R5 busy after tick", v, 8'h80);
        rd_reg(8'h00, v); check("R5 sec held while busy", v, 8'h30);
        repeat (UIP + 4) @(posedge clk);
        rd_reg(8'h0A, v); check("R5 busy cleared", v, 8'h00);
        rd_reg(8'h00, v); check("R3 sec advanced", v, 8'h31);
    endtask

    task automatic t_calendar();
        set_time(8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
        tick_and_wait();
        rd_reg(8'h00, v); check("R3 sec wrap", v, 8'h00);
        rd_reg(8'h02, v); check("R3 min wrap", v, 8'h00);
        rd_reg(8'h04, v); check("R3 hour wrap", v, 8'h00);
        rd_reg(8'h06, v); check("R3 wday 7 to 1", v, 8'h01);
        rd_reg(8'h07, v); check("R4 common feb day", v, 8'h01);
        rd_reg(8'h08, v); check("R4 common feb month", v, 8'h03);
        set_time(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        tick_and_wait();
        rd_reg(8'h07, v); check("R4 leap feb 29", v, 8'h29);
        rd_reg(8'h08, v); check("R4 leap month", v, 8'h02);
        set_time(8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        tick_and_wait();
        rd_reg(8'h07, v); check("R4 april 30 day", v, 8'h01);
        rd_reg(8'h08, v); check("R4 april 30 month", v, 8'h05);
        set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        tick_and_wait();
        rd_reg(8'h09, v); check("R3 year wrap", v, 8'h00);
        rd_reg(8'h08, v); check("R3 month wrap", v, 8'h01);
        rd_reg(8'h07, v); check("R3 day wrap", v, 8'h01);
        rd_reg(8'h06, v); check("R3 wday", v, 8'h06);
    endtask

    task automatic t_freeze();
        wr_reg(8'h0B, 8'h82);
        wr_reg(8'h00, 8'h10);
        tick_and_wait();
        rd_reg(8'h0A, v); check("R6 no busy frozen", v, 8'h00);
        rd_reg(8'h00, v); check("R6 sec frozen", v, 8'h10);
        wr_reg(8'h0B, 8'h02);
        tick_and_wait();
        rd_reg(8'h00, v); check("R6 resume", v, 8'h11);
    endtask

    task automatic t_alarm();
        set_time(8'h24, 8'h06, 8'h01, 8'h01, 8'h12, 8'h34, 8'h59);
        wr_reg(8'h01, 8'h00); wr_reg(8'h03, 8'h35); wr_reg(8'h05, 8'h12);
        wr_reg(8'h0B, 8'h22);
        rd_reg(8'h0C, junk);
        tick_and_wait();
        check("R10 irq on alarm", {7'd0, irq}, 8'h01);
        rd_reg(8'h0C, v); check("R7 R9 exact alarm flags", v, 8'hB0);
        check("R10 irq cleared by read", {7'd0, irq}, 8'h00);
        wr_reg(8'h01, 8'h01); wr_reg(8'h03, 8'hC5); wr_reg(8'h05, 8'hC0);
        tick_and_wait();
        rd_reg(8'h0C, v); check("R7 wildcard alarm", v, 8'hB0);
        tick_and_wait();
        rd_reg(8'h0C, v); check("R7 R9 no match update only", v, 8'h10);
        check("R10 irq low for disabled flag", {7'd0, irq}, 8'h00);
        wr_reg(8'h0B, 8'h02);
    endtask

    task automatic t_periodic();
        @(negedge clk); base_en = 1'b0;
        rd_reg(8'h0C, junk);
        wr_reg(8'h0C, 8'hFF);
        rd_reg(8'h0C, v); check("R9 write ignored", v, 8'h00);
        wr_reg(8'h0A, 8'h23);
        pulse_base(3);
        rd_reg(8'h0C, v); check("R8 not yet", v, 8'h00);
        pulse_base(1);
        rd_reg(8'h0C, v); check("R8 periodic flag", v, 8'h40);
        wr_reg(8'h0B, 8'h42);
        pulse_base(4);
        check("R10 irq periodic", {7'd0, irq}, 8'h01);
        rd_reg(8'h0C, v); check("R8 R9 summary", v, 8'hC0);
        wr_reg(8'h0A, 8'h20);
        pulse_base(20);
        rd_reg(8'h0C, v); check("R8 rate zero off", v, 8'h00);
        wr_reg(8'h0B, 8'h02);
        @(negedge clk); base_en = 1'b1;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_access();
        t_busy();
        t_calendar();
        t_freeze();
        t_alarm();
        t_periodic();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule